// File: doc/BRIEF.md
# Transmit Retry Attempt Controller

This block sequences the transmit attempts of one frame on a half-duplex MAC. A frame-start request opens a frame and launches the first attempt. While an attempt runs, the block counts the bytes the serializer reports. A collision seen before the protected byte window closes starts a retransmission after a fixed idle gap. A collision seen after the window closes ends the frame with a late-collision status and no further attempt. An end-of-frame report with no collision ends the frame with success.

A mode bit chooses between normal retry operation, which allows up to `MAX_ATTEMPTS` attempts, and single-shot operation. The same bit decides whether the transmit FIFO is told to hold the first `PROT_BYTES` bytes for replay. The bit is sampled when the frame starts. A test input injects a collision into every attempt, but only while the internal-loopback qualifier is also high. This lets the retry-error path be driven without a medium.

Top module: `tx_retry_ctl`

## Requirements
- R1: After reset, `tx_go_o`, `busy_o`, `protect_o`, `ok_o`, `retry_err_o` and `late_col_o` are 0 and `attempt_o` is 0.
- R2: A `start_i` pulse while idle makes `tx_go_o` high for exactly one cycle in the next cycle, with `busy_o`=1 and `attempt_o`=1.
- R3: With `no_retry_i`=0 at frame start, each counted collision that is not on the last attempt causes a new `tx_go_o` pulse, and `attempt_o` increments by one. A counted collision while `attempt_o`=`MAX_ATTEMPTS` pulses `retry_err_o`, and no further `tx_go_o` follows.
- R4: With `no_retry_i`=1 at frame start, only one attempt is made, and a counted collision pulses `retry_err_o`.
- R5: While a frame is busy, `protect_o` equals the inverse of the `no_retry_i` value sampled at frame start. `protect_o` is 0 from the cycle in which the result pulse appears.
- R6: A collision counts only when fewer than `PROT_BYTES` `byte_i` strobes have been seen in the current attempt. With `PROT_BYTES` or more strobes, the collision pulses `late_col_o`, ends the frame, and makes no retry.
- R7: `done_i` in an attempt with no collision pulses `ok_o` and ends the frame.
- R8: If a counted collision is applied in cycle c and the frame is not finished, the next `tx_go_o` is high in cycle c+`GAP_CYCLES`+1 and low in the cycles between.
- R9: With `force_col_i`=1 and `int_loop_i`=1, every attempt collides at its first cycle, so the frame ends in `retry_err_o`. With `int_loop_i`=0, `force_col_i` has no effect.
- R10: `start_i` while busy is ignored: `attempt_o` and the gap timing are unchanged.
- R11: `ok_o`, `retry_err_o` and `late_col_o` are single-cycle pulses and never high together. A collision and `done_i` in the same cycle are treated as a collision.
- R12: `attempt_o` returns to 0 in the cycle the frame result is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame-start request (used only when idle) |
| no_retry_i | input | 1 | Single-attempt mode, sampled at frame start |
| force_col_i | input | 1 | Test: force collision on every attempt |
| int_loop_i | input | 1 | Internal loopback active (qualifies force_col_i) |
| col_i | input | 1 | Collision from medium side |
| byte_i | input | 1 | One byte sent in the current attempt |
| done_i | input | 1 | Serializer finished the current attempt |
| tx_go_o | output | 1 | Launch an attempt (one-cycle pulse) |
| busy_o | output | 1 | Frame in progress |
| protect_o | output | 1 | FIFO must keep the first PROT_BYTES bytes |
| attempt_o | output | $clog2(MAX_ATTEMPTS+1) | Current attempt number, 0 when idle |
| ok_o | output | 1 | Frame sent successfully (pulse) |
| retry_err_o | output | 1 | Attempt limit exhausted (pulse) |
| late_col_o | output | 1 | Collision after protect window (pulse) |

## Verification
The bench builds the block with `MAX_ATTEMPTS`=16 and `PROT_BYTES`=64, the full retry depth and window size, and with `GAP_CYCLES`=5. A shorter gap lets a run of sixteen forced collisions finish in a few hundred cycles and still leaves room to count the quiet cycles before each relaunch. With a 64-byte window, the 63-byte and 64-byte collision boundary is reachable with directed strobes. The random frames mix early, late and clean endings across both retry modes.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_OK   = 2'd1,
    END_ERR  = 2'd2,
    END_LATE = 2'd3
  } tx_end_e;
endpackage

// File: rtl/tx_retry_window.sv
module tx_retry_window #(
  parameter int PROT_BYTES = 64,
  localparam int CW = $clog2(PROT_BYTES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic byte_i,
  output logic open_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clear_i)                           cnt_q <= '0;
    else if (byte_i && cnt_q != CW'(PROT_BYTES)) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q < CW'(PROT_BYTES));
endmodule

// File: rtl/tx_retry_gap.sv
module tx_retry_gap #(
  parameter int GAP_CYCLES = 8,
  localparam int CW = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= CW'(GAP_CYCLES - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/tx_retry_attempts.sv
module tx_retry_attempts #(
  parameter int MAX_ATTEMPTS = 16,
  localparam int CW = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          first_i,
  input  logic          inc_i,
  input  logic          single_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (first_i) cnt_q <= CW'(1);
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign last_o  = single_i ? (cnt_q == CW'(1)) : (cnt_q == CW'(MAX_ATTEMPTS));
endmodule

// File: rtl/tx_retry_ctl.sv
module tx_retry_ctl
  import tx_retry_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int PROT_BYTES   = 64,
  parameter int GAP_CYCLES   = 8,
  localparam int AW = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          no_retry_i,
  input  logic          force_col_i,
  input  logic          int_loop_i,
  input  logic          col_i,
  input  logic          byte_i,
  input  logic          done_i,
  output logic          tx_go_o,
  output logic          busy_o,
  output logic          protect_o,
  output logic [AW-1:0] attempt_o,
  output logic          ok_o,
  output logic          retry_err_o,
  output logic          late_col_o
);
  tx_state_e state_q, state_d;
  tx_end_e   end_d;
  logic single_q;
  logic go_q, ok_q, err_q, late_q;
  logic go_d, first_d, inc_d, clr_d, win_clr_d, gap_load_d;
  logic win_open, gap_done, at_last, eff_col;

  // loopback qualifies the test collision
  assign eff_col = col_i | (force_col_i & int_loop_i);

  tx_retry_window #(.PROT_BYTES(PROT_BYTES)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (win_clr_d),
    .byte_i  (byte_i & (state_q == ST_XMIT)),
    .open_o  (win_open)
  );

  tx_retry_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load_d),
    .done_o (gap_done)
  );

  tx_retry_attempts #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_att (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clr_d),
    .first_i  (first_d),
    .inc_i    (inc_d),
    .single_i (single_q),
    .count_o  (attempt_o),
    .last_o   (at_last)
  );

  always_comb begin
    state_d    = state_q;
    end_d      = END_NONE;
    go_d       = 1'b0;
    first_d    = 1'b0;
    inc_d      = 1'b0;
    clr_d      = 1'b0;
    win_clr_d  = 1'b0;
    gap_load_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_XMIT;
          first_d   = 1'b1;
          win_clr_d = 1'b1;
          go_d      = 1'b1;
        end
      end
      ST_XMIT: begin
        if (eff_col) begin
          if (!win_open) begin
            state_d = ST_IDLE;
            end_d   = END_LATE;
            clr_d   = 1'b1;
          end else if (at_last) begin
            state_d = ST_IDLE;
            end_d   = END_ERR;
            clr_d   = 1'b1;
          end else begin
            state_d    = ST_GAP;
            gap_load_d = 1'b1;
          end
        end else if (done_i) begin
          state_d = ST_IDLE;
          end_d   = END_OK;
          clr_d   = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          state_d   = ST_XMIT;
          inc_d     = 1'b1;
          win_clr_d = 1'b1;
          go_d      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
      go_q     <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      late_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      ok_q    <= (end_d == END_OK);
      err_q   <= (end_d == END_ERR);
      late_q  <= (end_d == END_LATE);
      if (state_q == ST_IDLE && start_i) single_q <= no_retry_i;
    end
  end

  assign tx_go_o     = go_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign protect_o   = busy_o & ~single_q;
  assign ok_o        = ok_q;
  assign retry_err_o = err_q;
  assign late_col_o  = late_q;
endmodule

// File: rtl/tx_retry_ctl_chk.sv
module tx_retry_ctl_chk #(
  parameter int MAX_ATTEMPTS = 16,
  localparam int AW = $clog2(MAX_ATTEMPTS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          tx_go_o,
  input logic          busy_o,
  input logic          protect_o,
  input logic [AW-1:0] attempt_o,
  input logic          ok_o,
  input logic          retry_err_o,
  input logic          late_col_o
);
  assert_go_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |=> !tx_go_o);

  assert_start_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (tx_go_o && attempt_o == AW'(1)));

  assert_err_at_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_err_o |-> ($past(attempt_o) == AW'(1) || $past(attempt_o) == AW'(MAX_ATTEMPTS)));

  assert_no_count_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o <= AW'(MAX_ATTEMPTS));

  assert_protect_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_o |-> busy_o);

  assert_result_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, retry_err_o, late_col_o}));

  assert_result_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || retry_err_o || late_col_o) |=> !(ok_o || retry_err_o || late_col_o));

  assert_count_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || retry_err_o || late_col_o) |-> (attempt_o == '0 && !busy_o));
endmodule

bind tx_retry_ctl tx_retry_ctl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .tx_go_o     (tx_go_o),
  .busy_o      (busy_o),
  .protect_o   (protect_o),
  .attempt_o   (attempt_o),
  .ok_o        (ok_o),
  .retry_err_o (retry_err_o),
  .late_col_o  (late_col_o)
);

// File: tb/sim_tx_retry_ctl.sv
module sim_tx_retry_ctl;
  localparam int MAXA = 16;
  localparam int PROT = 64;
  localparam int GAP  = 5;
  localparam int AW   = $clog2(MAXA + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, nr = 0, fc = 0, lp = 0, col = 0, byt = 0, done = 0;
  logic go, busy, prot, ok, err, late;
  logic [AW-1:0] att;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tx_retry_ctl #(.MAX_ATTEMPTS(MAXA), .PROT_BYTES(PROT), .GAP_CYCLES(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .no_retry_i(nr),
    .force_col_i(fc), .int_loop_i(lp), .col_i(col), .byte_i(byt), .done_i(done),
    .tx_go_o(go), .busy_o(busy), .protect_o(prot), .attempt_o(att),
    .ok_o(ok), .retry_err_o(err), .late_col_o(late));

  task automatic chk(input bit pass, input string req, input int act, input int exp);
    checks++;
    if (!pass) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int limit_of(input bit single);
    return single ? 1 : MAXA;
  endfunction

  // act: 0 early collision, 1 late collision, 2 clean end, 3 collision with done
  task automatic attempt(input int act, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      byt = 1; tick(); byt = 0;
    end
    col  = (act != 2);
    done = (act >= 2);
    tick();
    col = 0; done = 0;
  endtask

  task automatic run_frame(input bit f_nr, input bit f_fc, input bit f_lp,
                           input int fix_act, input int fix_n);
    int lim = limit_of(f_nr);
    bit forced = f_fc & f_lp;
    nr = f_nr; fc = f_fc; lp = f_lp;
    start = 1; tick(); start = 0;
    chk(go == 1, "R2 go after start", go, 1);
    chk(att == AW'(1), "R2 attempt after start", att, 1);
    chk(prot == !f_nr, "R5 protect in frame", prot, !f_nr);
    nr = $urandom % 2;
    for (int a = 1; a <= MAXA; a++) begin
      int act, n, r;
      r = $urandom % 100;
      act = forced ? 0 : (fix_act >= 0 ? fix_act : (r < 60 ? 0 : (r < 75 ? 1 : 2)));
      if (forced) n = 0;
      else if (fix_n >= 0) n = fix_n;
      else if (act == 1) n = PROT + ($urandom % 12);
      else if (act == 2) n = 1 + ($urandom % 80);
      else n = $urandom % PROT;
      attempt(act, n);
      if (act == 1) begin
        chk(late == 1, "R6 late collision", late, 1);
        chk(err == 0 && ok == 0, "R11 exclusive", {err, ok}, 0);
      end else if (act == 2) begin
        chk(ok == 1, "R7 success", ok, 1);
        chk(err == 0 && late == 0, "R11 exclusive", {err, late}, 0);
      end else if (a == lim) begin
        chk(err == 1, f_nr ? "R4 single-shot error" : (forced ? "R9 forced error" : "R3 retry error"), err, 1);
        chk(ok == 0 && late == 0, "R11 exclusive", {ok, late}, 0);
      end else begin
        chk(err == 0 && ok == 0 && late == 0, "R6 counted collision", {err, ok, late}, 0);
        chk(prot == !f_nr, "R5 protect during gap", prot, !f_nr);
        for (int g = 1; g < GAP; g++) begin
          chk(go == 0, "R8 quiet gap", go, 0);
          tick();
        end
        tick();
        chk(go == 1, "R8 relaunch after gap", go, 1);
        chk(att == AW'(a + 1), "R3 attempt increments", att, a + 1);
        continue;
      end
      chk(att == '0, "R12 counter cleared", att, 0);
      chk(prot == 0 && busy == 0, "R5 protect drops", prot, 0);
      tick();
      chk(go == 0 && ok == 0 && err == 0 && late == 0, "R11 no trailing pulse", {go, ok, err, late}, 0);
      break;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    tick(); tick();
    chk(go == 0 && busy == 0 && prot == 0 && ok == 0 && err == 0 && late == 0,
        "R1 reset outputs", {go, busy, prot, ok, err, late}, 0);
    chk(att == '0, "R1 reset attempt", att, 0);
    rst_n = 1; tick();

    run_frame(0, 1, 1, -1, -1);  // R9 full-depth forced
    run_frame(1, 1, 1, -1, -1);  // R4/R9 single-shot forced
    run_frame(0, 1, 0, 2, 10);   // R9 force ignored without loopback
    run_frame(1, 0, 0, 0, 20);   // R4 single collision
    run_frame(0, 0, 0, 1, PROT); // R6 boundary: 64 bytes -> late
    // R6 boundary: 63 bytes still counted, then R7 finish
    nr = 0; start = 1; tick(); start = 0;
    attempt(0, PROT - 1);
    chk(late == 0 && err == 0, "R6 63 bytes counted", late, 0);
    for (int g = 0; g < GAP; g++) tick();
    chk(go == 1 && att == AW'(2), "R6 retry after 63 bytes", att, 2);
    // R11 collision wins over done
    attempt(3, 4);
    chk(ok == 0 && busy == 1, "R11 collision beats done", ok, 0);
    // R10 start during gap ignored
    start = 1; tick(); start = 0;
    chk(att == AW'(2) && go == 0, "R10 start ignored while busy", att, 2);
    for (int g = 1; g < GAP; g++) tick();
    chk(go == 1 && att == AW'(3), "R10 gap timing unchanged", att, 3);
    attempt(2, 5);
    chk(ok == 1, "R7 success after retries", ok, 1);
    tick();

    for (int f = 0; f < 40; f++)
      run_frame(($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2, -1, -1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule